// File: doc/BRIEF.md
# Configuration Reset-Handshake Sequencer

This block is the hardware sequencer that takes a programmable-logic region through a full reload and then hands it back. On a start request in full mode it clamps the fabric resets, closes the level shifters and reopens only the processor-to-logic direction. It then runs a three-step program-pulse handshake against the region's init status. Each step waits on init under its own timeout. After the handshake it waits for the region's done indication. When done is seen it opens both level-shifter directions and releases the fabric resets.

In partial mode the reset, level-shifter and program-pulse steps are skipped. Only the wait for done remains, and none of the three output fields move.

All waits sample their condition on a poll tick. The tick comes from a clock prescaler of `TICK_CYCLES` cycles. A wait fails after `TIMEOUT_TICKS` ticks without the condition. A failure stops the sequencer in state FAIL. The failed phase is latched, and every output keeps its last value until the next start.

States: IDLE, RST_ON, LS_OFF, LS_P2L, WAIT_HI1, WAIT_LO, WAIT_HI2, WAIT_DONE, LS_ALL, RST_REL, FAIL.

Transitions:
- IDLE/FAIL to RST_ON on a full start.
- IDLE/FAIL to WAIT_DONE on a partial start.
- RST_ON to LS_OFF, LS_OFF to LS_P2L, and LS_P2L to WAIT_HI1, one cycle each.
- WAIT_HI1 to WAIT_LO on a tick with init high.
- WAIT_LO to WAIT_HI2 on a tick with init low.
- WAIT_HI2 to WAIT_DONE on a tick with init high.
- WAIT_DONE to LS_ALL on a tick with done high in full mode, or to IDLE in partial mode.
- LS_ALL to RST_REL, and RST_REL to IDLE.
- Any WAIT state to FAIL on the last tick without its condition.

Top module: `cfg_reset_sequencer`

## Requirements
- R1: After reset, the outputs hold these values: `fab_rst_o`=0x0, `lvl_en_o`=0x0, `prog_o`=1, and `busy_o`, `cfg_done_o`, `err_o` all 0. `err_phase_o` is 0.
- R2: A full start (`start_i`=1, `partial_i`=0) sampled at edge E0 has three effects. `fab_rst_o` becomes 0xF and `busy_o` becomes 1 at E0. `lvl_en_o` becomes 0x0 at E0+1 and 0xA at E0+2.
- R3: The program output is driven 1 at E0+3. It goes to 0 once init is seen high. It goes back to 1 once init is then seen low. The sequencer then moves on to the done wait once init is seen high again.
- R4: A wait state entered at edge W samples its condition only at edges W+k·TICK_CYCLES (k≥1). Any change of output caused by the wait happens at such an edge.
- R5: A wait fails at edge W+TIMEOUT_TICKS·TICK_CYCLES if its condition was never seen at a tick. A condition first seen at that last tick still counts as a pass.
- R6: In full mode, after done is seen at a tick, `lvl_en_o` becomes 0xF at that edge. `fab_rst_o` becomes 0x0 one edge later. `cfg_done_o` rises and `busy_o` falls one edge after that.
- R7: A partial start (`partial_i`=1) waits only for done. `fab_rst_o`, `lvl_en_o` and `prog_o` do not change. `cfg_done_o` rises at the done tick.
- R8: On a failure, `busy_o` falls and `err_o` rises, and all field outputs hold their values. `err_phase_o` names the failed wait: 1 = first init rise, 2 = init fall, 3 = second init rise, 4 = done.
- R9: A start seen while `busy_o`=1 is ignored, and the running sequence keeps its timing.
- R10: `err_o` and `err_phase_o` stay set until the next accepted start. That start clears them and `cfg_done_o` at E0.
- R11: `prog_o` is 0 only while `fab_rst_o` is 0xF. `fab_rst_o` is released only after `lvl_en_o` is 0xF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when not busy |
| partial_i | input | 1 | 1 selects partial mode at start |
| init_i | input | 1 | Region init status |
| done_i | input | 1 | Region done indication |
| fab_rst_o | output | 4 | Fabric reset lines, 0xF all asserted |
| lvl_en_o | output | 4 | Level-shifter enable field |
| prog_o | output | 1 | Program signal, active low |
| busy_o | output | 1 | Sequence in progress |
| cfg_done_o | output | 1 | Last sequence completed |
| err_o | output | 1 | Sticky timeout flag |
| err_phase_o | output | 3 | Failed-phase code |

## Verification
Every output is a register that changes at the clock edge that samples its cause. The one-cycle steps land at E0+1 and E0+2. Every wait result lands exactly TICK_CYCLES edges after the previous wait transition, and a timeout lands TIMEOUT_TICKS·TICK_CYCLES edges after the wait was entered. The bench drives inputs and reads outputs at falling edges. It steps a counted number of falling edges from the start edge to each due point, and it checks both the cycle just before a due change and the cycle of the change. A shift by one tick or by one cycle therefore shows up as a mismatch.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam int FIELD_W = 4;

    localparam logic [FIELD_W-1:0] RST_ALL  = 4'hF;
    localparam logic [FIELD_W-1:0] RST_NONE = 4'h0;
    localparam logic [FIELD_W-1:0] LS_CLOSED = 4'h0;
    localparam logic [FIELD_W-1:0] LS_P2L    = 4'hA;
    localparam logic [FIELD_W-1:0] LS_BOTH   = 4'hF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_ON,
        ST_LS_OFF,
        ST_LS_P2L,
        ST_WAIT_HI1,
        ST_WAIT_LO,
        ST_WAIT_HI2,
        ST_WAIT_DONE,
        ST_LS_ALL,
        ST_RST_REL,
        ST_FAIL
    } seq_state_t;

    typedef enum logic [2:0] {
        PH_NONE  = 3'd0,
        PH_RISE1 = 3'd1,
        PH_FALL  = 3'd2,
        PH_RISE2 = 3'd3,
        PH_DONE  = 3'd4
    } fail_phase_t;

endpackage

// File: rtl/cfgseq_poll_timer.sv
module cfgseq_poll_timer #(
    parameter int TICK_CYCLES   = 4000,
    parameter int TIMEOUT_TICKS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o,
    output logic expire_o
);

    localparam int PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);
    localparam logic [TW-1:0] TCNT_LAST = TW'(TIMEOUT_TICKS - 1);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] tcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tcnt_q <= '0;
        end else if (!run_i || restart_i) begin
            pre_q  <= '0;
            tcnt_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            if (tcnt_q != TCNT_LAST)
                tcnt_q <= tcnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick_o   = run_i && (pre_q == PRE_LAST);
    assign expire_o = tick_o && (tcnt_q == TCNT_LAST);

    // Ticks are TICK_CYCLES apart, so two never come back to back (R4).
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((TICK_CYCLES > 1) && tick_o) |=> !tick_o);

endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
    import cfgseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               partial_i,
    input  logic               init_i,
    input  logic               done_i,
    input  logic               tick_i,
    input  logic               expire_i,
    output logic               run_o,
    output logic               restart_o,
    output logic [FIELD_W-1:0] fab_rst_o,
    output logic [FIELD_W-1:0] lvl_en_o,
    output logic               prog_o,
    output logic               busy_o,
    output logic               cfg_done_o,
    output logic               err_o,
    output logic [2:0]         err_phase_o
);

    seq_state_t state_q, state_n;
    logic       partial_q;
    logic       accept;

    assign accept = start_i && (state_q == ST_IDLE || state_q == ST_FAIL);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE, ST_FAIL: begin
                if (start_i)
                    state_n = partial_i ? ST_WAIT_DONE : ST_RST_ON;
            end
            ST_RST_ON: state_n = ST_LS_OFF;
            ST_LS_OFF: state_n = ST_LS_P2L;
            ST_LS_P2L: state_n = ST_WAIT_HI1;
            ST_WAIT_HI1: begin
                if (tick_i && init_i)  state_n = ST_WAIT_LO;
                else if (expire_i)     state_n = ST_FAIL;
            end
            ST_WAIT_LO: begin
                if (tick_i && !init_i) state_n = ST_WAIT_HI2;
                else if (expire_i)     state_n = ST_FAIL;
            end
            ST_WAIT_HI2: begin
                if (tick_i && init_i)  state_n = ST_WAIT_DONE;
                else if (expire_i)     state_n = ST_FAIL;
            end
            ST_WAIT_DONE: begin
                if (tick_i && done_i)  state_n = partial_q ? ST_IDLE : ST_LS_ALL;
                else if (expire_i)     state_n = ST_FAIL;
            end
            ST_LS_ALL:  state_n = ST_RST_REL;
            ST_RST_REL: state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    assign run_o = (state_q == ST_WAIT_HI1) || (state_q == ST_WAIT_LO) ||
                   (state_q == ST_WAIT_HI2) || (state_q == ST_WAIT_DONE);
    assign restart_o = (state_n != state_q);
    assign busy_o = (state_q != ST_IDLE) && (state_q != ST_FAIL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            partial_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (accept)
                partial_q <= partial_i;
        end
    end

    // Output registers, updated on entry to a state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fab_rst_o   <= RST_NONE;
            lvl_en_o    <= LS_CLOSED;
            prog_o      <= 1'b1;
            cfg_done_o  <= 1'b0;
            err_o       <= 1'b0;
            err_phase_o <= PH_NONE;
        end else begin
            if (accept) begin
                cfg_done_o  <= 1'b0;
                err_o       <= 1'b0;
                err_phase_o <= PH_NONE;
            end
            if (state_n != state_q) begin
                unique case (state_n)
                    ST_RST_ON:   fab_rst_o <= RST_ALL;
                    ST_LS_OFF:   lvl_en_o  <= LS_CLOSED;
                    ST_LS_P2L:   lvl_en_o  <= LS_P2L;
                    ST_WAIT_HI1: prog_o    <= 1'b1;
                    ST_WAIT_LO:  prog_o    <= 1'b0;
                    ST_WAIT_HI2: prog_o    <= 1'b1;
                    ST_LS_ALL:   lvl_en_o  <= LS_BOTH;
                    ST_RST_REL:  fab_rst_o <= RST_NONE;
                    ST_IDLE:     cfg_done_o <= 1'b1;
                    ST_FAIL: begin
                        err_o <= 1'b1;
                        unique case (state_q)
                            ST_WAIT_HI1: err_phase_o <= PH_RISE1;
                            ST_WAIT_LO:  err_phase_o <= PH_FALL;
                            ST_WAIT_HI2: err_phase_o <= PH_RISE2;
                            default:     err_phase_o <= PH_DONE;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the program pulse goes low only under full fabric reset
    p_prog_under_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_o |-> (fab_rst_o == RST_ALL));

    // R6: resets are released only once both shifter directions are open
    p_release_after_ls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fab_rst_o == RST_NONE && $past(fab_rst_o) == RST_ALL) |-> (lvl_en_o == LS_BOTH));

    // R2: the shifter field only takes the three defined codes
    p_lvl_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_en_o == LS_CLOSED) || (lvl_en_o == LS_P2L) || (lvl_en_o == LS_BOTH));

    // R8: a failed sequence is never reported as busy
    p_busy_not_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && err_o));

    // R10: the error flag persists until a start arrives
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o);

    // R7: a partial run leaves the fields alone
    p_partial_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && partial_q) |-> ($stable(fab_rst_o) && $stable(lvl_en_o) && $stable(prog_o)));

    // R6: completion is only raised as the sequencer goes idle
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done_o) |-> !busy_o);

endmodule

// File: rtl/cfg_reset_sequencer.sv
module cfg_reset_sequencer #(
    parameter int TICK_CYCLES   = 4000,
    parameter int TIMEOUT_TICKS = 125000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       partial_i,
    input  logic       init_i,
    input  logic       done_i,
    output logic [3:0] fab_rst_o,
    output logic [3:0] lvl_en_o,
    output logic       prog_o,
    output logic       busy_o,
    output logic       cfg_done_o,
    output logic       err_o,
    output logic [2:0] err_phase_o
);

    logic tick, expire, run, restart;

    cfgseq_poll_timer #(
        .TICK_CYCLES  (TICK_CYCLES),
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .restart_i(restart),
        .tick_o   (tick),
        .expire_o (expire)
    );

    cfgseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .partial_i  (partial_i),
        .init_i     (init_i),
        .done_i     (done_i),
        .tick_i     (tick),
        .expire_i   (expire),
        .run_o      (run),
        .restart_o  (restart),
        .fab_rst_o  (fab_rst_o),
        .lvl_en_o   (lvl_en_o),
        .prog_o     (prog_o),
        .busy_o     (busy_o),
        .cfg_done_o (cfg_done_o),
        .err_o      (err_o),
        .err_phase_o(err_phase_o)
    );

endmodule

// File: tb/cfg_reset_sequencer_test.sv
`timescale 1ns/1ps
module cfg_reset_sequencer_test;

    localparam int TC = 4;
    localparam int TO = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic partial_i = 1'b0;
    logic init_i = 1'b0;
    logic done_i = 1'b0;
    logic [3:0] fab_rst_o, lvl_en_o;
    logic prog_o, busy_o, cfg_done_o, err_o;
    logic [2:0] err_phase_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    // 0 follow prog, 1 stuck low, 2 stuck high, 4 follow until prog seen low, then low
    int init_mode = 0;
    bit low_seen = 0;

    always #2.5 clk = ~clk;

    cfg_reset_sequencer #(.TICK_CYCLES(TC), .TIMEOUT_TICKS(TO)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
        .init_i(init_i), .done_i(done_i), .fab_rst_o(fab_rst_o),
        .lvl_en_o(lvl_en_o), .prog_o(prog_o), .busy_o(busy_o),
        .cfg_done_o(cfg_done_o), .err_o(err_o), .err_phase_o(err_phase_o));

    // Region model for init
    initial forever begin
        @(negedge clk);
        if (init_mode != 4) low_seen = 0;
        case (init_mode)
            1: init_i = 1'b0;
            2: init_i = 1'b1;
            4: begin
                if (!prog_o) low_seen = 1;
                init_i = prog_o && !low_seen;
            end
            default: init_i = prog_o;
        endcase
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic go(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Returns at the falling edge just after start edge E0
    task automatic pulse_start(input bit p);
        @(negedge clk);
        start_i = 1'b1;
        partial_i = p;
        @(negedge clk);
        start_i = 1'b0;
        partial_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 fab_rst", 32'(fab_rst_o), 32'h0);
        chk("R1 lvl_en", 32'(lvl_en_o), 32'h0);
        chk("R1 prog", 32'(prog_o), 32'h1);
        chk("R1 busy", 32'(busy_o), 32'h0);
        chk("R1 done", 32'(cfg_done_o), 32'h0);
        chk("R1 err", 32'(err_o), 32'h0);
        chk("R1 phase", 32'(err_phase_o), 32'h0);
    endtask

    task automatic t_full(input bit inject);
        logic [3:0] pre_lvl;
        init_mode = 0;
        done_i = 1'b1;
        pre_lvl = lvl_en_o;
        pulse_start(1'b0);                                   // N0
        chk("R2 fab_rst all", 32'(fab_rst_o), 32'hF);
        chk("R2 busy", 32'(busy_o), 32'h1);
        chk("R2 lvl unchanged", 32'(lvl_en_o), 32'(pre_lvl));
        chk("R10 err cleared", 32'(err_o), 32'h0);
        chk("R10 phase cleared", 32'(err_phase_o), 32'h0);
        chk("R10 done cleared", 32'(cfg_done_o), 32'h0);
        go(1);                                               // N1
        chk("R2 lvl closed", 32'(lvl_en_o), 32'h0);
        go(1);                                               // N2
        chk("R2 lvl p2l", 32'(lvl_en_o), 32'hA);
        go(1);                                               // N3
        chk("R3 prog high", 32'(prog_o), 32'h1);
        if (inject) begin
            go(2);                                           // N5
            start_i = 1'b1; partial_i = 1'b1;
            go(1);                                           // N6
            start_i = 1'b0; partial_i = 1'b0;
            chk("R9 fab kept", 32'(fab_rst_o), 32'hF);
        end else begin
            go(3);                                           // N6
        end
        chk("R4 prog before tick", 32'(prog_o), 32'h1);
        go(1);                                               // N7
        chk(inject ? "R9 prog low" : "R3 prog low", 32'(prog_o), 32'h0);
        go(3);                                               // N10
        chk("R4 prog low held", 32'(prog_o), 32'h0);
        go(1);                                               // N11
        chk("R3 prog high again", 32'(prog_o), 32'h1);
        go(7);                                               // N18
        chk("R4 lvl before done tick", 32'(lvl_en_o), 32'hA);
        go(1);                                               // N19
        chk("R6 lvl both", 32'(lvl_en_o), 32'hF);
        chk("R6 fab still held", 32'(fab_rst_o), 32'hF);
        go(1);                                               // N20
        chk("R6 fab released", 32'(fab_rst_o), 32'h0);
        chk("R6 busy", 32'(busy_o), 32'h1);
        go(1);                                               // N21
        chk(inject ? "R9 done" : "R6 done", 32'(cfg_done_o), 32'h1);
        chk("R6 idle", 32'(busy_o), 32'h0);
    endtask

    task automatic t_partial;
        done_i = 1'b1;
        pulse_start(1'b1);                                   // N0
        chk("R7 busy", 32'(busy_o), 32'h1);
        chk("R7 fab untouched", 32'(fab_rst_o), 32'h0);
        chk("R7 lvl untouched", 32'(lvl_en_o), 32'hF);
        go(3);                                               // N3
        chk("R7 busy before tick", 32'(busy_o), 32'h1);
        go(1);                                               // N4
        chk("R7 done", 32'(cfg_done_o), 32'h1);
        chk("R7 idle", 32'(busy_o), 32'h0);
        chk("R7 fab", 32'(fab_rst_o), 32'h0);
        chk("R7 lvl", 32'(lvl_en_o), 32'hF);
        chk("R7 prog", 32'(prog_o), 32'h1);
    endtask

    task automatic t_partial_timeout;
        done_i = 1'b0;
        pulse_start(1'b1);                                   // N0
        go(19);                                              // N19
        chk("R5 no err before last tick", 32'(err_o), 32'h0);
        chk("R5 busy", 32'(busy_o), 32'h1);
        go(1);                                               // N20
        chk("R5 err", 32'(err_o), 32'h1);
        chk("R8 phase done", 32'(err_phase_o), 32'h4);
        chk("R8 not busy", 32'(busy_o), 32'h0);
        go(10);
        chk("R10 err sticky", 32'(err_o), 32'h1);
        chk("R8 lvl held", 32'(lvl_en_o), 32'hF);
        chk("R8 fab held", 32'(fab_rst_o), 32'h0);
    endtask

    task automatic t_rise1_timeout;
        init_mode = 1;
        pulse_start(1'b0);
        go(22);                                              // N22
        chk("R5 busy rise1", 32'(busy_o), 32'h1);
        go(1);                                               // N23
        chk("R8 err rise1", 32'(err_o), 32'h1);
        chk("R8 phase rise1", 32'(err_phase_o), 32'h1);
        go(8);
        chk("R8 fab held", 32'(fab_rst_o), 32'hF);
        chk("R8 lvl held", 32'(lvl_en_o), 32'hA);
        chk("R8 prog held", 32'(prog_o), 32'h1);
    endtask

    task automatic t_fall_timeout;
        init_mode = 2;
        pulse_start(1'b0);
        go(7);                                               // N7
        chk("R3 prog low", 32'(prog_o), 32'h0);
        go(19);                                              // N26
        chk("R5 no err fall", 32'(err_o), 32'h0);
        go(1);                                               // N27
        chk("R8 phase fall", 32'(err_phase_o), 32'h2);
        chk("R8 prog held low", 32'(prog_o), 32'h0);
    endtask

    task automatic t_rise2_timeout;
        init_mode = 0;
        pulse_start(1'b0);
        go(3);                                               // N3
        init_mode = 4;
        go(27);                                              // N30
        chk("R5 no err rise2", 32'(err_o), 32'h0);
        go(1);                                               // N31
        chk("R8 phase rise2", 32'(err_phase_o), 32'h3);
        chk("R8 prog held high", 32'(prog_o), 32'h1);
    endtask

    task automatic t_boundary;
        init_mode = 1;
        done_i = 1'b1;
        pulse_start(1'b0);
        go(20);                                              // N20
        init_mode = 0;
        go(2);                                               // N22
        chk("R5 prog before last tick", 32'(prog_o), 32'h1);
        go(1);                                               // N23
        chk("R5 pass on last tick", 32'(prog_o), 32'h0);
        chk("R5 no err at last tick", 32'(err_o), 32'h0);
        go(14);                                              // N37
        chk("R5 done after late init", 32'(cfg_done_o), 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        go(2);
        t_full(1'b0);
        go(3);
        t_full(1'b1);
        go(2);
        t_partial();
        go(2);
        t_partial_timeout();
        go(2);
        t_full(1'b0);
        go(2);
        t_rise1_timeout();
        t_fall_timeout();
        t_rise2_timeout();
        t_boundary();
        go(2);
        t_partial();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule